// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between eight interrupt sources and an 8-bit CPU. The sources are the raster line, UART A receive-ready and transmit-done, two timer channels, UART B receive-ready and transmit-done, and frame blank. In vectored mode each source has a fixed priority and a fixed vector byte of its own. The block latches each request as a pending bit and drives the shared active-low interrupt line. During the acknowledge cycle it places the vector of the winning source on the data bus. It keeps an in-service mask so that handlers can nest. A source that outranks every handler now running can preempt it. Any other request waits until a handler returns.

A handler return counts only when the CPU fetches the two opcode bytes ED and 4D in sequence. Software controls the block through input ports: a per-source enable, a trigger that sets a pending bit, and a write-one-to-clear of pending bits. When the mode input is low the block falls back to a plain level interrupt with no vector. In that mode nothing is latched, so a request that drops before it is serviced is lost.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the pending and in-service masks are zero, int_no_o is high and vec_o is 8'hFF.
- R2: In vectored mode, a rising edge on src_req_i[i] sets pending bit i at the next clock edge.
- R3: In vectored mode, a one-cycle pulse on sw_trig_i[i] sets pending bit i at the next clock edge.
- R4: A pulse on clr_i[i] clears pending bit i at the next clock edge.
- R5: A source whose src_en_i bit is low still latches as pending but does not drive int_no_o. Raising the enable delivers it.
- R6: Index 0 has the highest priority and index 7 the lowest. The order is line, UART A rx, UART A tx, timer 0, timer 1, UART B rx, UART B tx, frame. While int_no_o is low, vec_o equals VEC_BASE + 2*index of the winner, with bit 0 zero (default base 8'h20).
- R7: An acknowledge (iack_i high while int_no_o is low) clears the winner's pending bit and sets its in-service bit.
- R8: A pending source preempts only if its index is lower than every in-service index. A request of equal or lower priority is held.
- R9: An opcode fetch of 8'h4D whose most recent earlier opcode fetch was 8'hED clears the lowest-index in-service bit. A held request is then delivered.
- R10: Other return opcodes (8'hC9, ED 45), or a 4D fetch with no ED prefix before it, leave the in-service mask unchanged.
- R11: With hw_mode_i low, int_no_o is low exactly while some enabled src_req_i level is high. No pending bit is latched, and vec_o is 8'hFF.
- R12: In vectored mode, int_no_o is low exactly when an enabled pending source outranks all in-service sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_mode_i | input | 1 | 1 selects vectored mode, 0 selects level mode |
| src_req_i | input | 8 | Source request levels, bit index = priority |
| src_en_i | input | 8 | Per-source enable |
| sw_trig_i | input | 8 | Software trigger pulses |
| clr_i | input | 8 | Write-one-to-clear pulses for pending bits |
| iack_i | input | 1 | Interrupt acknowledge cycle |
| m1_i | input | 1 | Opcode fetch strobe |
| data_i | input | 8 | Data bus during opcode fetch |
| pend_o | output | 8 | Pending mask |
| insvc_o | output | 8 | In-service mask |
| int_no_o | output | 1 | Interrupt request to the CPU, active low |
| vec_o | output | 8 | Vector byte for the acknowledge cycle |

## Verification
The hardest state to reach is a request that is held behind a running handler and then delivered late. It needs a handler already in service, a new request of equal or lower rank, and then a complete ED 4D fetch pair. The bench builds this for every ordered pair of sources. It triggers the first source and acknowledges it, then raises the second. It checks that the interrupt line is held or preempts as the ranks require. It then retires each handler and checks the late vector. A separate sequence feeds near-miss return opcodes with a handler live.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned N_SRC_DEF = 8;
  localparam int unsigned VEC_W_DEF = 8;

  typedef enum logic [2:0] {
    SRC_LINE    = 3'd0,
    SRC_UA_RX   = 3'd1,
    SRC_UA_TX   = 3'd2,
    SRC_TMR0    = 3'd3,
    SRC_TMR1    = 3'd4,
    SRC_UB_RX   = 3'd5,
    SRC_UB_TX   = 3'd6,
    SRC_FRAME   = 3'd7
  } src_e;

  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETI   = 8'h4D;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int unsigned N_SRC = vic_pkg::N_SRC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_mode_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic set_b;
    assign set_b = hw_mode_i && ((req_i[g] && !req_q[g]) || trig_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                  pend_o[g] <= 1'b0;
      else if (set_b)               pend_o[g] <= 1'b1;
      else if (clr_i[g] || ack_i[g]) pend_o[g] <= 1'b0;
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int unsigned N_SRC = vic_pkg::N_SRC_DEF,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] insvc_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] allow, cand;

  // bits strictly above the top in-service rank; all ones when idle
  assign allow = (insvc_i & (~insvc_i + N_SRC'(1))) - N_SRC'(1);
  assign cand  = pend_i & en_i & allow;
  assign hit_o = |cand;

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (cand[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/vic_reti.sv
module vic_reti (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       m1_i,
  input  logic [7:0] data_i,
  output logic       pop_o
);
  logic pfx_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   pfx_q <= 1'b0;
    else if (m1_i) pfx_q <= (data_i == vic_pkg::OP_PREFIX);

  assign pop_o = m1_i && pfx_q && (data_i == vic_pkg::OP_RETI);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned N_SRC = vic_pkg::N_SRC_DEF,
  parameter int unsigned VEC_W = vic_pkg::VEC_W_DEF,
  parameter logic [VEC_W-1:0] VEC_BASE = VEC_W'(8'h20)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_mode_i,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] sw_trig_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             iack_i,
  input  logic             m1_i,
  input  logic [7:0]       data_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] insvc_o,
  output logic             int_no_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic             hit, pop, take;
  logic [IDX_W-1:0] idx;
  logic [N_SRC-1:0] ack_oh, insvc_q, insvc_d;

  vic_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .hw_mode_i,
    .req_i(src_req_i), .trig_i(sw_trig_i), .clr_i(clr_i),
    .ack_i(ack_oh), .pend_o(pend_o)
  );

  vic_arb #(.N_SRC(N_SRC)) u_arb (
    .pend_i(pend_o), .en_i(src_en_i), .insvc_i(insvc_q),
    .hit_o(hit), .idx_o(idx)
  );

  vic_reti u_reti (.clk_i, .rst_ni, .m1_i, .data_i, .pop_o(pop));

  assign take   = hw_mode_i && hit && iack_i;
  assign ack_oh = take ? (N_SRC'(1) << idx) : '0;

  always_comb begin
    insvc_d = pop ? (insvc_q & (insvc_q - N_SRC'(1))) : insvc_q;
    insvc_d = insvc_d | ack_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) insvc_q <= '0;
    else         insvc_q <= insvc_d;

  assign insvc_o  = insvc_q;
  assign int_no_o = hw_mode_i ? !hit : !(|(src_req_i & src_en_i));

  always_comb begin
    vec_o = '1;
    if (hw_mode_i && hit)
      vec_o = (VEC_BASE + VEC_W'({idx, 1'b0})) & ~VEC_W'(1);
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = VEC_W'(8'h20)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_mode_i,
  input logic             iack_i,
  input logic             m1_i,
  input logic [7:0]       data_i,
  input logic [N_SRC-1:0] src_en_i,
  input logic [N_SRC-1:0] clr_i,
  input logic [N_SRC-1:0] pend_o,
  input logic [N_SRC-1:0] insvc_o,
  input logic             int_no_o,
  input logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] off;
  int unsigned      widx;
  logic [N_SRC-1:0] rank_mask;

  always_comb begin
    off       = (vec_o - VEC_BASE) >> 1;
    widx      = int'(off) % N_SRC;
    rank_mask = N_SRC'((64'd2 << widx) - 64'd1);
  end

  // R6: delivered vector is even and inside the table
  p_vec_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && !int_no_o) |-> (vec_o[0] == 1'b0 && int'(off) < N_SRC));

  // R5: a disabled source never wins
  p_en_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && !int_no_o) |-> src_en_i[widx]);

  // R8: the winner outranks everything in service
  p_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && !int_no_o) |-> ((insvc_o & rank_mask) == '0));

  // R7: acknowledge adds an in-service bit
  p_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && iack_i && !int_no_o) |=> ((insvc_o & ~$past(insvc_o)) != '0));

  // R9: back-to-back ED 4D fetch retires exactly one handler
  p_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_i && data_i == 8'h4D && $past(m1_i && data_i == 8'hED) && !iack_i && insvc_o != '0)
    |=> ($countones(insvc_o) + 1 == $countones($past(insvc_o))));

  // R11: level mode latches nothing
  p_lvl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_mode_i && clr_i == '0) |=> $stable(pend_o));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_mode_i(hw_mode_i), .iack_i(iack_i),
  .m1_i(m1_i), .data_i(data_i), .src_en_i(src_en_i), .clr_i(clr_i),
  .pend_o(pend_o), .insvc_o(insvc_o), .int_no_o(int_no_o), .vec_o(vec_o)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam logic [7:0] BASE = 8'h20;

  logic       clk_i = 1'b0, rst_ni = 1'b0, hw_mode_i = 1'b1;
  logic [7:0] src_req_i = '0, src_en_i = 8'hFF, sw_trig_i = '0, clr_i = '0;
  logic       iack_i = 1'b0, m1_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] pend_o, insvc_o, vec_o;
  logic       int_no_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vec_irq_ctrl u_vec_irq_ctrl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic trig(int i);
    sw_trig_i = 8'(1 << i); cyc(); sw_trig_i = '0;
  endtask

  task automatic pulse(logic [7:0] m);
    src_req_i = m; cyc(); src_req_i = '0;
  endtask

  task automatic ack(output logic [7:0] v);
    iack_i = 1'b1; #1 v = vec_o; cyc(); iack_i = 1'b0;
  endtask

  task automatic fetch(logic [7:0] op);
    m1_i = 1'b1; data_i = op; cyc(); m1_i = 1'b0; data_i = '0;
  endtask

  task automatic reti();
    fetch(8'hED); fetch(8'h4D);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    #1;
    chk("R1 int", int_no_o, 1); chk("R1 vec", vec_o, 8'hFF);
    chk("R1 pend", pend_o, 0); chk("R1 insvc", insvc_o, 0);
    @(negedge clk_i); rst_ni = 1'b1; cyc();

    // per-source edge latch, vector, ack, retire
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk("R2 pend", pend_o, 32'(1 << i));
      chk("R12 int", int_no_o, 0);
      ack(v);
      chk("R6 vec", v, 32'(BASE + 8'(2 * i)));
      chk("R7 pend", pend_o, 0);
      chk("R7 insvc", insvc_o, 32'(1 << i));
      chk("R12 idle", int_no_o, 1);
      reti();
      chk("R9 pop", insvc_o, 0);
    end

    // every ordered pair: a in service, b arrives
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        trig(a);
        chk("R3 trig", pend_o, 32'(1 << a));
        ack(v);
        pulse(8'(1 << b));
        if (b < a) begin
          chk("R8 preempt", int_no_o, 0);
          ack(v);
          chk("R8 vec", v, 32'(BASE + 8'(2 * b)));
          chk("R8 nest", insvc_o, 32'((1 << a) | (1 << b)));
          reti();
          chk("R9 inner", insvc_o, 32'(1 << a));
          reti();
        end else begin
          chk("R8 held", int_no_o, 1);
          reti();
          chk("R9 late", int_no_o, 0);
          ack(v);
          chk("R9 late vec", v, 32'(BASE + 8'(2 * b)));
          reti();
        end
        chk("R9 empty", insvc_o, 0);
      end

    // near-miss returns
    trig(2); ack(v);
    fetch(8'hC9);                 chk("R10 ret", insvc_o, 8'h04);
    fetch(8'hED); fetch(8'h45);   chk("R10 retn", insvc_o, 8'h04);
    fetch(8'h4D);                 chk("R10 bare", insvc_o, 8'h04);
    fetch(8'hED); cyc(); fetch(8'h4D);
    chk("R9 gap", insvc_o, 0);

    // enable masking and clear
    src_en_i = 8'hFB; trig(2);
    chk("R5 latch", pend_o, 8'h04); chk("R5 mask", int_no_o, 1);
    src_en_i = 8'hFF; #1 chk("R5 deliver", int_no_o, 0);
    clr_i = 8'h04; cyc(); clr_i = '0;
    chk("R4 clr", pend_o, 0); chk("R4 int", int_no_o, 1);

    // simultaneous requests
    pulse(8'h81); chk("R2 both", pend_o, 8'h81);
    ack(v); chk("R6 top", v, BASE);
    chk("R8 low held", int_no_o, 1);
    reti(); ack(v); chk("R6 frame", v, BASE + 8'd14);
    reti(); chk("R9 clean", insvc_o, 0);

    // level mode
    hw_mode_i = 1'b0;
    src_req_i = 8'h08; #1 chk("R11 low", int_no_o, 0); chk("R11 vec", vec_o, 8'hFF);
    cyc(); chk("R11 nolatch", pend_o, 0);
    src_req_i = '0; #1 chk("R11 lost", int_no_o, 1);
    trig(5); chk("R11 notrig", pend_o, 0);
    src_en_i = 8'hF7; src_req_i = 8'h08; #1 chk("R11 en", int_no_o, 1);
    src_req_i = '0; src_en_i = 8'hFF; hw_mode_i = 1'b1; cyc();
    chk("R11 after", int_no_o, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule